// File: doc/BRIEF.md
# Control-Word Sequencer

The block runs a datapath that has no instruction decoder. A control memory holds precompiled control words. Each word carries every control signal the datapath needs for one clock cycle. The sequencer reads one word per cycle, splits it into fixed-width fields and drives each field onto the control port of the unit it steers. It also issues read addresses to the input data memories in step with the words: the received-symbol and fading-factor memories are addressed by symbol index, and the constellation table by program step.

A frame is processed as nested loops. The inner loop is a per-symbol microprogram of configurable length that starts at a configurable base address. This program runs once per symbol of the frame, and the whole frame repeats for a configurable number of iterations. The symbol order can be forward, reverse, or alternating between iterations. A one-cycle pulse marks the cycle in which each symbol's final word is applied, and a second one-cycle pulse closes the frame. A busy output frames the whole run, and new start requests are ignored while it is high.

The control memory is synchronous with one cycle of read latency. The address is issued one cycle ahead of the cycle in which the word is applied.

Top module: `cw_sequencer`

## Requirements
- R1: A start pulse while busy_o is low latches all configuration inputs. On the next cycle busy_o rises and the first fetch is issued at cfg_base_i. Later changes on the configuration inputs have no effect on the running frame.
- R2: While fetching, cm_en_o is high and cm_addr_o steps by one per cycle from the base address (modulo 2^CM_AW). After the last step of the program it returns to the base address.
- R3: The word read at a fetched address appears on ctl_fld_o in the following cycle, with field k taken from word bits [k*FW +: FW]. In every other cycle all fields are zero.
- R4: cst_addr_o carries the step index within the symbol program, in the same cycle as the matching cm_addr_o.
- R5: sym_addr_o carries the symbol index and stays constant over a symbol's program. cfg_order_i selects the order: 0 gives forward order, 1 gives reverse order (last index first), 2 gives forward order on even iterations and reverse order on odd ones, and 3 behaves as 0.
- R6: sym_ready_o is high for exactly the cycle in which the last word of each symbol program is applied. In every applied cycle, sym_o and iter_o give the symbol index and iteration of the applied word.
- R7: The symbol index advances when a program ends, and the iteration advances when the last symbol ends. A frame is exactly L*S*I fetches with no gaps.
- R8: frame_done_o pulses high for one cycle, in the cycle after the final word is applied. busy_o is low on the following cycle.
- R9: A start pulse while busy_o is high is ignored. The running frame's addresses, fields and flags continue unchanged.
- R10: The length configuration inputs encode the last index, so a value of 0 means a count of one. With all three at 0 the frame is a single fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a frame (ignored while busy) |
| cfg_base_i | input | CM_AW | Control-memory address of the symbol program |
| cfg_last_step_i | input | CM_AW | Program length minus one |
| cfg_last_sym_i | input | SYM_W | Symbols per frame minus one |
| cfg_last_iter_i | input | ITER_W | Iterations minus one |
| cfg_order_i | input | 2 | Symbol order mode |
| cm_en_o | output | 1 | Control-memory read enable |
| cm_addr_o | output | CM_AW | Control-memory read address |
| cm_rdata_i | input | NF*FW | Control word, one cycle after address |
| ctl_fld_o | output | NF*FW | Control fields to the datapath, packed NF x FW |
| sym_addr_o | output | SYM_W | Received-symbol and fading-factor read address |
| cst_addr_o | output | CM_AW | Constellation-table read address |
| sym_o | output | SYM_W | Symbol index of the applied word |
| iter_o | output | ITER_W | Iteration of the applied word |
| sym_ready_o | output | 1 | Last word of a symbol applied |
| frame_done_o | output | 1 | Frame complete pulse |
| busy_o | output | 1 | Frame in progress |

## Verification
The hardest situation to reach from the ports is a start request landing in the middle of a running frame, together with different configuration values. One scenario raises start_i several cycles into a frame with new settings. It then checks that every remaining address, field and flag still follows the original configuration. Every run also alters the configuration inputs right after the start pulse, so latching is observed at the outputs. A program base near the top of the address space is used to force the address to wrap. A single-step program is used to make sym_ready_o fire on every applied cycle.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic [1:0] {
    ORD_FWD = 2'd0,
    ORD_REV = 2'd1,
    ORD_ALT = 2'd2,
    ORD_RSV = 2'd3
  } sym_order_e;
endpackage

// File: rtl/cw_loop_ctr.sv
module cw_loop_ctr #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = inc_i && (cnt_q == last_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> cnt_q <= last_i); // R7
endmodule

// File: rtl/cw_fetch.sv
module cw_fetch
  import cw_pkg::*;
#(
  parameter int CM_AW  = 8,
  parameter int SYM_W  = 6,
  parameter int ITER_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic [CM_AW-1:0]  cfg_base_i,
  input  logic [CM_AW-1:0]  cfg_last_step_i,
  input  logic [SYM_W-1:0]  cfg_last_sym_i,
  input  logic [ITER_W-1:0] cfg_last_iter_i,
  input  logic [1:0]        cfg_order_i,
  output logic              fetch_o,
  output logic [CM_AW-1:0]  cm_addr_o,
  output logic [CM_AW-1:0]  cst_addr_o,
  output logic [SYM_W-1:0]  sym_idx_o,
  output logic [ITER_W-1:0] iter_o,
  output logic              step_last_o,
  output logic              frame_last_o
);
  logic              launch;
  logic              fetch_q;
  logic [CM_AW-1:0]  base_q, lstep_q;
  logic [SYM_W-1:0]  lsym_q;
  logic [ITER_W-1:0] liter_q;
  sym_order_e        ord_q;

  logic [CM_AW-1:0]  step;
  logic [SYM_W-1:0]  sym;
  logic [ITER_W-1:0] iter;
  logic              step_wrap, sym_wrap, iter_wrap;

  assign launch = start_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      lstep_q <= '0;
      lsym_q  <= '0;
      liter_q <= '0;
      ord_q   <= ORD_FWD;
    end else if (launch) begin
      base_q  <= cfg_base_i;
      lstep_q <= cfg_last_step_i;
      lsym_q  <= cfg_last_sym_i;
      liter_q <= cfg_last_iter_i;
      ord_q   <= sym_order_e'(cfg_order_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fetch_q <= 1'b0;
    else if (launch)    fetch_q <= 1'b1;
    else if (iter_wrap) fetch_q <= 1'b0;
  end

  cw_loop_ctr #(.W(CM_AW)) u_step (
    .clk_i, .rst_ni, .clr_i(launch), .inc_i(fetch_q),
    .last_i(lstep_q), .cnt_o(step), .wrap_o(step_wrap));

  cw_loop_ctr #(.W(SYM_W)) u_sym (
    .clk_i, .rst_ni, .clr_i(launch), .inc_i(step_wrap),
    .last_i(lsym_q), .cnt_o(sym), .wrap_o(sym_wrap));

  cw_loop_ctr #(.W(ITER_W)) u_iter (
    .clk_i, .rst_ni, .clr_i(launch), .inc_i(sym_wrap),
    .last_i(liter_q), .cnt_o(iter), .wrap_o(iter_wrap));

  // symbol order: reverse counts down from the last index
  always_comb begin
    unique case (ord_q)
      ORD_REV: sym_idx_o = lsym_q - sym;
      ORD_ALT: sym_idx_o = iter[0] ? (lsym_q - sym) : sym;
      default: sym_idx_o = sym;
    endcase
  end

  assign fetch_o      = fetch_q;
  assign cm_addr_o    = base_q + step;
  assign cst_addr_o   = step;
  assign iter_o       = iter;
  assign step_last_o  = step_wrap;
  assign frame_last_o = iter_wrap;

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_q && $past(fetch_q) && !$past(step_wrap)
      |-> cm_addr_o == $past(cm_addr_o) + 1'b1); // R2
  AST_ADDR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_q && $past(fetch_q) && $past(step_wrap) |-> cm_addr_o == base_q); // R2
  AST_SYM_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_q && $past(fetch_q) && !$past(step_wrap) |-> $stable(sym_idx_o)); // R5
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(base_q) && $stable(lstep_q) && $stable(lsym_q)); // R9
endmodule

// File: rtl/cw_apply.sv
module cw_apply #(
  parameter int NF     = 4,
  parameter int FW     = 8,
  parameter int SYM_W  = 6,
  parameter int ITER_W = 4,
  localparam int CW_W  = NF * FW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fetch_i,
  input  logic                   step_last_i,
  input  logic                   frame_last_i,
  input  logic [SYM_W-1:0]       sym_i,
  input  logic [ITER_W-1:0]      iter_i,
  input  logic [CW_W-1:0]        cm_rdata_i,
  output logic [NF-1:0][FW-1:0]  ctl_fld_o,
  output logic                   sym_ready_o,
  output logic [SYM_W-1:0]       sym_o,
  output logic [ITER_W-1:0]      iter_o,
  output logic                   active_o,
  output logic                   done_o
);
  logic              apply_q, last_step_q, last_frame_q, done_q;
  logic [SYM_W-1:0]  sym_q;
  logic [ITER_W-1:0] iter_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      apply_q      <= 1'b0;
      last_step_q  <= 1'b0;
      last_frame_q <= 1'b0;
      done_q       <= 1'b0;
      sym_q        <= '0;
      iter_q       <= '0;
    end else begin
      apply_q      <= fetch_i;
      last_step_q  <= fetch_i && step_last_i;
      last_frame_q <= fetch_i && frame_last_i;
      done_q       <= apply_q && last_frame_q;
      if (fetch_i) begin
        sym_q  <= sym_i;
        iter_q <= iter_i;
      end
    end
  end

  // field k drives its own datapath unit; gated to zero outside applied cycles
  for (genvar k = 0; k < NF; k++) begin : g_fld
    assign ctl_fld_o[k] = apply_q ? cm_rdata_i[k*FW +: FW] : '0;
  end

  assign sym_ready_o = apply_q && last_step_q;
  assign sym_o       = sym_q;
  assign iter_o      = iter_q;
  assign active_o    = apply_q;
  assign done_o      = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(sym_ready_o) && !apply_q); // R8
  AST_READY_IN_APPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_ready_o |-> $past(fetch_i)); // R6
endmodule

// File: rtl/cw_sequencer.sv
module cw_sequencer
  import cw_pkg::*;
#(
  parameter int CM_AW  = 8,
  parameter int SYM_W  = 6,
  parameter int ITER_W = 4,
  parameter int NF     = 4,
  parameter int FW     = 8,
  localparam int CW_W  = NF * FW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [CM_AW-1:0]      cfg_base_i,
  input  logic [CM_AW-1:0]      cfg_last_step_i,
  input  logic [SYM_W-1:0]      cfg_last_sym_i,
  input  logic [ITER_W-1:0]     cfg_last_iter_i,
  input  logic [1:0]            cfg_order_i,
  output logic                  cm_en_o,
  output logic [CM_AW-1:0]      cm_addr_o,
  input  logic [CW_W-1:0]       cm_rdata_i,
  output logic [NF-1:0][FW-1:0] ctl_fld_o,
  output logic [SYM_W-1:0]      sym_addr_o,
  output logic [CM_AW-1:0]      cst_addr_o,
  output logic [SYM_W-1:0]      sym_o,
  output logic [ITER_W-1:0]     iter_o,
  output logic                  sym_ready_o,
  output logic                  frame_done_o,
  output logic                  busy_o
);
  logic              fetch;
  logic [SYM_W-1:0]  f_sym;
  logic [ITER_W-1:0] f_iter;
  logic              step_last, frame_last, apply_active;

  assign busy_o  = fetch || apply_active || frame_done_o;
  assign cm_en_o = fetch;

  cw_fetch #(.CM_AW(CM_AW), .SYM_W(SYM_W), .ITER_W(ITER_W)) u_fetch (
    .clk_i, .rst_ni, .start_i, .busy_i(busy_o),
    .cfg_base_i, .cfg_last_step_i, .cfg_last_sym_i, .cfg_last_iter_i, .cfg_order_i,
    .fetch_o(fetch), .cm_addr_o, .cst_addr_o,
    .sym_idx_o(f_sym), .iter_o(f_iter),
    .step_last_o(step_last), .frame_last_o(frame_last));

  assign sym_addr_o = f_sym;

  cw_apply #(.NF(NF), .FW(FW), .SYM_W(SYM_W), .ITER_W(ITER_W)) u_apply (
    .clk_i, .rst_ni, .fetch_i(fetch), .step_last_i(step_last),
    .frame_last_i(frame_last), .sym_i(f_sym), .iter_i(f_iter),
    .cm_rdata_i, .ctl_fld_o, .sym_ready_o, .sym_o, .iter_o,
    .active_o(apply_active), .done_o(frame_done_o));

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cm_en_o && ctl_fld_o == '0); // R3
  AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !busy_o); // R8
  AST_START_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> cm_en_o && cm_addr_o == $past(cfg_base_i)); // R1
endmodule

// File: tb/cw_sequencer_tb_top.sv
module cw_sequencer_tb_top;
  localparam int CM_AW = 8, SYM_W = 6, ITER_W = 4, NF = 4, FW = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [CM_AW-1:0]  cfg_base_i = '0, cfg_last_step_i = '0;
  logic [SYM_W-1:0]  cfg_last_sym_i = '0;
  logic [ITER_W-1:0] cfg_last_iter_i = '0;
  logic [1:0]        cfg_order_i = '0;
  logic              cm_en_o;
  logic [CM_AW-1:0]  cm_addr_o, cst_addr_o;
  logic [31:0]       cm_rdata_i = '0;
  logic [NF-1:0][FW-1:0] ctl_fld_o;
  logic [SYM_W-1:0]  sym_addr_o, sym_o;
  logic [ITER_W-1:0] iter_o;
  logic sym_ready_o, frame_done_o, busy_o;

  int vectors = 0;
  int errors  = 0;

  always #5 clk_i = ~clk_i;

  cw_sequencer dut_i (.*);

  function automatic logic [31:0] cw_of(input int a);
    logic [7:0] b;
    b = 8'(a);
    return {b ^ 8'hc3, b + 8'h37, ~b, b};
  endfunction

  always_ff @(posedge clk_i) if (cm_en_o) cm_rdata_i <= cw_of(int'(cm_addr_o));

  function automatic int ord_of(input int sym, input int it, input int ls, input int mode);
    if (mode == 1 || (mode == 2 && it % 2 == 1)) return ls - sym;
    return sym;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_frame(input int base, input int len, input int ns, input int ni,
                           input int mode, input bit poke);
    int n;
    n = len * ns * ni;
    @(negedge clk_i);
    cfg_base_i = 8'(base); cfg_last_step_i = 8'(len - 1);
    cfg_last_sym_i = 6'(ns - 1); cfg_last_iter_i = 4'(ni - 1);
    cfg_order_i = 2'(mode); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // R1: scramble configuration after launch
    cfg_base_i = 8'd77; cfg_last_step_i = 8'd9; cfg_last_sym_i = 6'd13;
    cfg_last_iter_i = 4'd5; cfg_order_i = 2'(3 - mode);
    for (int k = 1; k <= n + 3; k++) begin
      bit fe, ap;
      int i, st, sy, it;
      fe = (k <= n);
      ap = (k >= 2 && k <= n + 1);
      chk(cm_en_o == fe, "R2 cm_en", 32'(cm_en_o), 32'(fe));
      if (fe) begin
        i = k - 1; st = i % len; sy = (i / len) % ns; it = i / (len * ns);
        chk(cm_addr_o == 8'(base + st), (k == 1) ? "R1 first addr" : "R2 cm_addr",
            32'(cm_addr_o), 32'(8'(base + st)));
        chk(cst_addr_o == 8'(st), "R4 cst_addr", 32'(cst_addr_o), 32'(st));
        chk(sym_addr_o == 6'(ord_of(sy, it, ns - 1, mode)), "R5 sym_addr",
            32'(sym_addr_o), 32'(ord_of(sy, it, ns - 1, mode)));
      end
      if (ap) begin
        i = k - 2; st = i % len; sy = (i / len) % ns; it = i / (len * ns);
        chk(ctl_fld_o == cw_of(base + st), "R3 fields", ctl_fld_o, cw_of(base + st));
        chk(sym_ready_o == (st == len - 1), "R6 sym_ready", 32'(sym_ready_o), 32'(st == len - 1));
        chk(sym_o == 6'(ord_of(sy, it, ns - 1, mode)), "R6 sym_o",
            32'(sym_o), 32'(ord_of(sy, it, ns - 1, mode)));
        chk(iter_o == 4'(it), "R7 iter_o", 32'(iter_o), 32'(it));
      end else begin
        chk(ctl_fld_o == '0, "R3 idle fields", ctl_fld_o, 32'd0);
        chk(!sym_ready_o, "R6 idle ready", 32'(sym_ready_o), 32'd0);
      end
      chk(frame_done_o == (k == n + 2), "R8 frame_done", 32'(frame_done_o), 32'(k == n + 2));
      chk(busy_o == (k <= n + 2), poke ? "R9 busy" : "R8 busy", 32'(busy_o), 32'(k <= n + 2));
      start_i = (poke && (k == 3 || k == n + 2));
      @(negedge clk_i);
    end
    start_i = 1'b0;
  endtask

  task automatic t_reset;
    chk(!busy_o && !cm_en_o && !frame_done_o && !sym_ready_o, "R1 reset idle",
        {28'd0, busy_o, cm_en_o, frame_done_o, sym_ready_o}, 32'd0);
    chk(ctl_fld_o == '0, "R3 reset fields", ctl_fld_o, 32'd0);
  endtask

  task automatic t_basic;      run_frame(10, 3, 2, 2, 0, 1'b0); endtask
  task automatic t_rev_wrap;   run_frame(254, 4, 3, 1, 1, 1'b0); endtask
  task automatic t_alternate;  run_frame(40, 1, 4, 3, 2, 1'b0); endtask
  task automatic t_single;     run_frame(5, 1, 1, 1, 3, 1'b0); endtask // R10
  task automatic t_start_busy; run_frame(100, 2, 3, 2, 2, 1'b1); endtask // R9

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_rev_wrap();
    t_alternate();
    t_single();
    t_start_busy();
    t_basic();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule